// File: doc/BRIEF.md
# Three-Wire Serial Timekeeper Master

This block is the host side of a three-wire link to a real-time-clock device. The link has a chip-enable line that holds the device in reset while low, a serial clock, and a data line. The data line is split into a drive value, a drive enable and a sampled input, so that a pad or a bench model can join them. On a one-cycle request the block runs one of three operations and then pulses `done`:

- a burst read of the eight timekeeping registers into a 64-bit parallel bank;
- a set-time sequence, which writes the eight registers from a parallel bank;
- a single write to the write-protect register.

Timing is counted in half periods of the serial clock. `HALF_CYC` system cycles make one half period. The guard time after the enable rises and the quiet time after it falls are each a whole number of half periods. The bytes of every transfer travel least significant bit first. During a read, the block stops driving the data line once the command byte has gone out. It then samples each bit at the end of the clock-high half. At the end of a burst read, a sanity check looks for bits that must be zero and fields that must be non-zero, and raises `err` if any fail.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, `rtc_ce`, `sclk`, `sdo_oe`, `busy`, `done` and `err` are all 0.
- R2: `req_op` encodes the operation: 2'b00 is a burst read, 2'b01 is a set-time sequence and 2'b10 is a write-protect write. A request with 2'b11 is ignored, and so is any request made while `busy` is 1. An ignored request causes no link activity and does not set `busy`.
- R3: Every byte is sent or received least significant bit first, with eight clock pulses. Each clock-high and clock-low half lasts `HALF_CYC` cycles. `sdo` changes only while `sclk` is low, so it has been held for a full half period when the clock rises.
- R4: `sdo_oe` is 1 and `sclk` is 0 before `rtc_ce` rises. The first rising clock edge comes exactly `SETUP_HALVES` half periods after `rtc_ce` rises.
- R5: After `rtc_ce` falls, it stays low for at least `HOLD_HALVES` half periods before it rises again or `done` is pulsed. `busy` stays 1 throughout that quiet time.
- R6: A burst read sends command 0xBF and then releases the data line. It captures eight bytes, sampling each bit at the end of its clock-high half. Byte k of the register sequence lands in `rd_bank[8k+7:8k]`. The sequence is seconds, minutes, hours, day of month, month, weekday, year, write-protect.
- R7: A set-time sequence runs two separate transactions. The first sends 0x8E followed by 0x00. The second sends 0xBE, then bytes 0 to 6 of `wr_bank` in order, then 0x80 as the eighth register byte, whatever `wr_bank[63:56]` holds.
- R8: A write-protect write is one transaction that sends 0x8E followed by `wr_bank[63:56]`.
- R9: When a burst read completes, `err` is 1 in either of two cases. The first is that any of these bits is set: minutes bit 7, hours bit 6, day-of-month bits 7:6, month bits 7:5, weekday bits 7:3, or write-protect bits 6:0. The second is that day of month, month or weekday is zero. After any other operation, `err` is 0. `err` holds its value until the next completion.
- R10: `done` is a single-cycle pulse. It is raised in the same cycle that `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle operation request |
| req_op | input | 2 | Operation code (see R2) |
| wr_bank | input | 64 | Register bytes for writes; byte k in bits 8k+7:8k |
| rd_bank | output | 64 | Register bytes captured by the last burst read |
| busy | output | 1 | Operation in progress, including the quiet time |
| done | output | 1 | Completion pulse |
| err | output | 1 | Sanity-check failure of the last completed operation |
| rtc_ce | output | 1 | Device enable; low holds the device in reset |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Data line drive value |
| sdo_oe | output | 1 | Data line drive enable |
| sdi | input | 1 | Data line sampled value |

## Verification
The bench builds the block with `HALF_CYC` = 2, `SETUP_HALVES` = 4 and `HOLD_HALVES` = 3. With these values a full nine-byte burst takes a few hundred cycles, so several reads, a set-time sequence and a write-protect write all fit in a short run. The guard-time and half-period measurements then come out as exact nanosecond values that can be compared directly. The asymmetric guard counts also make it possible to tell the setup count from the quiet-time count. A non-unit divider means the tick counter actually wraps, which exercises the divider logic.

// File: rtl/rtc3w_pkg.sv
`timescale 1ns/1ps
package rtc3w_pkg;
   // Number of timekeeping registers moved by a burst
   localparam int NREG = 8;

   // Operation codes on req_op
   localparam logic [1:0] OP_READ = 2'b00;
   localparam logic [1:0] OP_SET  = 2'b01;
   localparam logic [1:0] OP_PROT = 2'b10;

   // Command bytes; bit 0 selects a read
   localparam logic [7:0] CMD_BURST_WR = 8'hBE;
   localparam logic [7:0] CMD_BURST_RD = 8'hBF;
   localparam logic [7:0] CMD_PROT_WR  = 8'h8E;

   localparam logic [7:0] PROT_SET = 8'h80;
   localparam logic [7:0] PROT_CLR = 8'h00;

   // Kind of a single framed transaction
   typedef enum logic [1:0] {
      K_RD = 2'd0,
      K_WR = 2'd1,
      K_PW = 2'd2
   } rtc3w_kind_e;
endpackage

// File: rtl/rtc3w_tick.sv
`timescale 1ns/1ps
module rtc3w_tick #(
   parameter int HALF_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/rtc3w_sanity.sv
`timescale 1ns/1ps
module rtc3w_sanity
   import rtc3w_pkg::*;
(
   input  logic [8*NREG-1:0] bank,
   output logic              bad
);
   // Bits that a healthy device always returns as zero, per register slot
   localparam logic [8*NREG-1:0] ZERO_MASK = {
      8'h7F,   // write-protect
      8'h00,   // year
      8'hF8,   // weekday
      8'hE0,   // month
      8'hC0,   // day of month
      8'h40,   // hours
      8'h80,   // minutes
      8'h00    // seconds
   };

   logic stray_bits;
   logic zero_field;

   assign stray_bits = |(bank & ZERO_MASK);
   assign zero_field = (bank[31:24] == 8'h00) || (bank[39:32] == 8'h00) ||
                       (bank[47:40] == 8'h00);
   assign bad = stray_bits || zero_field;
endmodule

// File: rtl/rtc3w_engine.sv
`timescale 1ns/1ps
module rtc3w_engine
   import rtc3w_pkg::*;
#(
   parameter int HALF_CYC     = 125,
   parameter int SETUP_HALVES = 4,
   parameter int HOLD_HALVES  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  rtc3w_kind_e           kind,
   input  logic [8*(NREG-1)-1:0] wbank,
   input  logic [7:0]            pval,
   input  logic                  sdi,
   output logic                  link_en,
   output logic                  sclk,
   output logic                  sdo,
   output logic                  sdo_oe,
   output logic                  rx_wr,
   output logic [2:0]            rx_idx,
   output logic [7:0]            rx_byte,
   output logic                  fin
);
   localparam int GMAX = (SETUP_HALVES > HOLD_HALVES) ? SETUP_HALVES : HOLD_HALVES;
   localparam int GW   = $clog2(GMAX + 1);
   localparam logic [GW-1:0] SETUP_LAST = GW'(SETUP_HALVES - 1);
   localparam logic [GW-1:0] HOLD_LAST  = GW'(HOLD_HALVES - 1);

   typedef enum logic [2:0] {E_IDLE, E_PREP, E_SETUP, E_SHIFT, E_HOLD} est_e;

   est_e        st;
   rtc3w_kind_e kd;
   logic [3:0]  byte_idx;
   logic [2:0]  bit_idx;
   logic [GW-1:0] gcnt;
   logic [7:0]  rx_sh;
   logic [7:0]  rx_nxt;
   logic [7:0]  tx_byte;
   logic [3:0]  last_byte;
   logic        capture;
   logic        run;
   logic        tick;

   assign run = (st == E_SETUP) || (st == E_SHIFT) || (st == E_HOLD);

   rtc3w_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   always_comb begin
      if (byte_idx == 4'd0) begin
         case (kd)
            K_RD:    tx_byte = CMD_BURST_RD;
            K_WR:    tx_byte = CMD_BURST_WR;
            default: tx_byte = CMD_PROT_WR;
         endcase
      end else if (kd == K_PW) begin
         tx_byte = pval;
      end else if (byte_idx == 4'(NREG)) begin
         tx_byte = PROT_SET;
      end else begin
         tx_byte = wbank[(int'(byte_idx) - 1) * 8 +: 8];
      end
   end

   always_comb begin
      rx_nxt          = rx_sh;
      rx_nxt[bit_idx] = sdi;
   end

   assign last_byte = (kd == K_PW) ? 4'd1 : 4'(NREG);
   assign capture   = (kd == K_RD) && (byte_idx != 4'd0);
   assign sdo       = sdo_oe & tx_byte[bit_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         kd       <= K_RD;
         link_en  <= 1'b0;
         sclk     <= 1'b0;
         sdo_oe   <= 1'b0;
         byte_idx <= '0;
         bit_idx  <= '0;
         gcnt     <= '0;
         rx_sh    <= '0;
         rx_wr    <= 1'b0;
         rx_idx   <= '0;
         rx_byte  <= '0;
         fin      <= 1'b0;
      end else begin
         rx_wr <= 1'b0;
         fin   <= 1'b0;
         case (st)
            E_IDLE: begin
               if (go) begin
                  kd       <= kind;
                  st       <= E_PREP;
                  sdo_oe   <= 1'b1;
                  sclk     <= 1'b0;
                  byte_idx <= '0;
                  bit_idx  <= '0;
                  gcnt     <= '0;
               end
            end
            E_PREP: begin
               st      <= E_SETUP;
               link_en <= 1'b1;
            end
            E_SETUP: begin
               if (tick) begin
                  if (gcnt == SETUP_LAST) begin
                     st   <= E_SHIFT;
                     sclk <= 1'b1;
                     gcnt <= '0;
                  end else begin
                     gcnt <= gcnt + 1'b1;
                  end
               end
            end
            E_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (capture) begin
                        rx_sh <= rx_nxt;
                        if (bit_idx == 3'd7) begin
                           rx_wr   <= 1'b1;
                           rx_idx  <= 3'(byte_idx - 4'd1);
                           rx_byte <= rx_nxt;
                        end
                     end
                     if (bit_idx == 3'd7) begin
                        bit_idx <= '0;
                        if (byte_idx == last_byte) begin
                           st      <= E_HOLD;
                           link_en <= 1'b0;
                        end else begin
                           byte_idx <= byte_idx + 4'd1;
                        end
                        if (byte_idx == 4'd0 && kd == K_RD) sdo_oe <= 1'b0;
                     end else begin
                        bit_idx <= bit_idx + 3'd1;
                     end
                  end
               end
            end
            E_HOLD: begin
               if (tick) begin
                  if (gcnt == HOLD_LAST) begin
                     st     <= E_IDLE;
                     fin    <= 1'b1;
                     sdo_oe <= 1'b0;
                     gcnt   <= '0;
                  end else begin
                     gcnt <= gcnt + 1'b1;
                  end
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // R1
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_en |-> !sclk);

   // R3
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> ($stable(sdo) && $stable(sdo_oe)));

   // R3
   sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> $past(tick));

   // R4
   oe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> (sdo_oe && !sclk));
endmodule

// File: rtl/rtc3w_master.sv
`timescale 1ns/1ps
module rtc3w_master
   import rtc3w_pkg::*;
#(
   parameter int HALF_CYC     = 125,
   parameter int SETUP_HALVES = 4,
   parameter int HOLD_HALVES  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_op,
   input  logic [63:0] wr_bank,
   output logic [63:0] rd_bank,
   output logic        busy,
   output logic        done,
   output logic        err,
   output logic        rtc_ce,
   output logic        sclk,
   output logic        sdo,
   output logic        sdo_oe,
   input  logic        sdi
);
   localparam int BANK_W = 8 * NREG;
   localparam int WB_W   = 8 * (NREG - 1);

   initial begin : p_param_chk
      assert (HALF_CYC >= 1)     else $error("HALF_CYC must be at least 1");
      assert (SETUP_HALVES >= 1) else $error("SETUP_HALVES must be at least 1");
      assert (HOLD_HALVES >= 1)  else $error("HOLD_HALVES must be at least 1");
      assert (BANK_W == 64)      else $error("bank width must be 64 bits");
   end

   typedef enum logic {T_IDLE, T_RUN} tst_e;

   tst_e        st;
   rtc3w_kind_e kind_q;
   logic [1:0]  op_q;
   logic [WB_W-1:0] bank_q;
   logic [7:0]  pval_q;
   logic        pend_burst;
   logic        go;
   logic        op_ok;
   logic        fin;
   logic        rx_wr;
   logic [2:0]  rx_idx;
   logic [7:0]  rx_byte;
   logic        bad;

   assign op_ok = (req_op == OP_READ) || (req_op == OP_SET) || (req_op == OP_PROT);

   rtc3w_engine #(
      .HALF_CYC    (HALF_CYC),
      .SETUP_HALVES(SETUP_HALVES),
      .HOLD_HALVES (HOLD_HALVES)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .kind    (kind_q),
      .wbank   (bank_q),
      .pval    (pval_q),
      .sdi     (sdi),
      .link_en (rtc_ce),
      .sclk    (sclk),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe),
      .rx_wr   (rx_wr),
      .rx_idx  (rx_idx),
      .rx_byte (rx_byte),
      .fin     (fin)
   );

   rtc3w_sanity u_sanity (
      .bank(rd_bank),
      .bad (bad)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= '0;
         else if (rx_wr && rx_idx == 3'(g))     q <= rx_byte;
      end
      assign rd_bank[8*g +: 8] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= T_IDLE;
         kind_q     <= K_RD;
         op_q       <= OP_READ;
         bank_q     <= '0;
         pval_q     <= '0;
         pend_burst <= 1'b0;
         go         <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         err        <= 1'b0;
      end else begin
         go   <= 1'b0;
         done <= 1'b0;
         case (st)
            T_IDLE: begin
               if (req_valid && op_ok) begin
                  st     <= T_RUN;
                  busy   <= 1'b1;
                  go     <= 1'b1;
                  op_q   <= req_op;
                  bank_q <= wr_bank[WB_W-1:0];
                  case (req_op)
                     OP_READ: begin
                        kind_q     <= K_RD;
                        pend_burst <= 1'b0;
                     end
                     OP_SET: begin
                        kind_q     <= K_PW;
                        pval_q     <= PROT_CLR;
                        pend_burst <= 1'b1;
                     end
                     default: begin
                        kind_q     <= K_PW;
                        pval_q     <= wr_bank[63:56];
                        pend_burst <= 1'b0;
                     end
                  endcase
               end
            end
            T_RUN: begin
               if (fin) begin
                  if (pend_burst) begin
                     pend_burst <= 1'b0;
                     kind_q     <= K_WR;
                     go         <= 1'b1;
                  end else begin
                     st   <= T_IDLE;
                     busy <= 1'b0;
                     done <= 1'b1;
                     err  <= (op_q == OP_READ) && bad;
                  end
               end
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   ce_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rtc_ce) |=> busy);

   // R2
   no_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(req_valid && op_ok)) |=> !busy);
endmodule

// File: tb/rtc3w_master_bench.sv
`timescale 1ns/1ps
module rtc3w_master_bench;
   localparam int HALF = 2;
   localparam int SETH = 4;
   localparam int HOLH = 3;
   localparam int TCK  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [63:0] wr_bank = '0;
   logic [63:0] rd_bank;
   logic        busy, done, err, rtc_ce, sclk, sdo, sdo_oe;
   logic        sdi = 1'b0;

   always #4 clk = ~clk;

   rtc3w_master #(.HALF_CYC(HALF), .SETUP_HALVES(SETH), .HOLD_HALVES(HOLH)) u_rtc3w_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .wr_bank(wr_bank), .rd_bank(rd_bank), .busy(busy), .done(done), .err(err),
      .rtc_ce(rtc_ce), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   // ---------------- device model ----------------
   logic [7:0] dreg [8];
   logic [7:0] tb_bytes [4][9];
   int         tnb [4];
   int         ntxn, nbit;
   logic [7:0] sh;
   bit         cur_rd;
   longint     t_en, t_r, t_off;
   longint     setup_ns, hi_min, hi_max, gap_min;
   bit         oe_ok, busy_at_off;

   task automatic clr_model();
      ntxn = 0; nbit = 0; cur_rd = 1'b0; sh = '0;
      setup_ns = -1; hi_min = 1000000; hi_max = 0; gap_min = 1000000;
      oe_ok = 1'b1; busy_at_off = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tnb[i] = 0;
         for (int j = 0; j < 9; j++) tb_bytes[i][j] = '0;
      end
   endtask

   always @(posedge rtc_ce) begin
      if (ntxn > 0 && ($time - t_off) < gap_min) gap_min = $time - t_off;
      t_en = $time;
      nbit = 0;
      cur_rd = 1'b0;
      if (!sdo_oe || sclk) oe_ok = 1'b0;
   end

   always @(negedge rtc_ce) begin
      t_off = $time;
      if (!busy) busy_at_off = 1'b0;
      ntxn++;
   end

   always @(posedge sclk) begin
      if (nbit == 0) setup_ns = $time - t_en;
      t_r = $time;
      sh[nbit % 8] = sdo;
      nbit++;
      if (nbit % 8 == 0 && ntxn < 4 && nbit / 8 <= 9) begin
         tb_bytes[ntxn][nbit/8 - 1] = sh;
         tnb[ntxn] = nbit / 8;
         if (nbit == 8 && sh == 8'hBF) cur_rd = 1'b1;
      end
   end

   always @(negedge sclk) begin
      if (($time - t_r) < hi_min) hi_min = $time - t_r;
      if (($time - t_r) > hi_max) hi_max = $time - t_r;
      if (cur_rd && nbit >= 8 && nbit - 8 < 64)
         sdi = dreg[(nbit - 8) / 8][(nbit - 8) % 8];
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [63:0] bank);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; wr_bank = bank;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (done !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done === 1'b1, req, {63'd0, done}, 64'd1);
   endtask

   task automatic set_dev(input logic [63:0] v);
      for (int i = 0; i < 8; i++) dreg[i] = v[8*i +: 8];
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk({rtc_ce, sclk, sdo_oe, busy, done, err} == 6'b0, "R1 reset state",
          {58'd0, rtc_ce, sclk, sdo_oe, busy, done, err}, 64'd0);
   endtask

   task automatic t_read_ok();
      logic [63:0] exp = 64'h80_24_07_12_31_12_30_59;
      set_dev(exp);
      clr_model();
      issue(2'b00, '0);
      repeat (5) @(negedge clk);
      issue(2'b01, 64'hFFFF_FFFF_FFFF_FFFF);   // made while busy: ignored
      wait_done("R10 read completes");
      chk(($time - t_off) >= HOLH * HALF * TCK, "R5 quiet time before done",
          64'($time - t_off), 64'(HOLH * HALF * TCK));
      chk(!busy, "R10 busy low with done", {63'd0, busy}, 64'd0);
      chk(rd_bank == exp, "R6 read bank", rd_bank, exp);
      chk(err == 1'b0, "R9 clean read", {63'd0, err}, 64'd0);
      chk(tb_bytes[0][0] == 8'hBF, "R6 read command", {56'd0, tb_bytes[0][0]}, 64'hBF);
      chk(tnb[0] == 9, "R6 byte count", 64'(tnb[0]), 64'd9);
      chk(ntxn == 1, "R2 request while busy ignored", 64'(ntxn), 64'd1);
      chk(setup_ns == SETH * HALF * TCK, "R4 setup guard", 64'(setup_ns), 64'(SETH * HALF * TCK));
      chk(hi_min == HALF * TCK && hi_max == HALF * TCK, "R3 clock high half",
          64'(hi_max), 64'(HALF * TCK));
      chk(oe_ok, "R4 data driven and clock low before enable", {63'd0, oe_ok}, 64'd1);
      chk(busy_at_off, "R5 busy during quiet time", {63'd0, busy_at_off}, 64'd1);
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", {63'd0, done}, 64'd0);
   endtask

   task automatic t_read_bad_bits();
      logic [63:0] v = 64'h80_24_07_12_31_12_B0_59;   // minutes bit 7 set
      set_dev(v);
      clr_model();
      issue(2'b00, '0);
      wait_done("R9 read completes");
      chk(err == 1'b1, "R9 stray minutes bit", {63'd0, err}, 64'd1);
      chk(rd_bank == v, "R6 raw bank kept", rd_bank, v);
   endtask

   task automatic t_read_zero_month();
      logic [63:0] v = 64'h80_24_07_00_31_12_30_59;
      set_dev(v);
      clr_model();
      issue(2'b00, '0);
      wait_done("R9 read completes");
      chk(err == 1'b1, "R9 zero month", {63'd0, err}, 64'd1);
   endtask

   task automatic t_protect();
      clr_model();
      issue(2'b10, 64'h80_00_00_00_00_00_00_00);
      wait_done("R8 protect completes");
      chk(ntxn == 1 && tnb[0] == 2, "R8 single two-byte transaction",
          64'(tnb[0]), 64'd2);
      chk(tb_bytes[0][0] == 8'h8E && tb_bytes[0][1] == 8'h80, "R8 protect bytes",
          {48'd0, tb_bytes[0][0], tb_bytes[0][1]}, 64'h8E80);
      chk(err == 1'b0, "R9 err cleared by write", {63'd0, err}, 64'd0);
   endtask

   task automatic t_set();
      logic [63:0] b = 64'h00_25_03_11_14_07_45_12;
      clr_model();
      issue(2'b01, b);
      wait_done("R7 set completes");
      chk(ntxn == 2, "R7 two transactions", 64'(ntxn), 64'd2);
      chk(tb_bytes[0][0] == 8'h8E && tb_bytes[0][1] == 8'h00 && tnb[0] == 2,
          "R7 protect clear", {48'd0, tb_bytes[0][0], tb_bytes[0][1]}, 64'h8E00);
      chk(tb_bytes[1][0] == 8'hBE && tnb[1] == 9, "R7 burst write command",
          {56'd0, tb_bytes[1][0]}, 64'hBE);
      for (int k = 0; k < 7; k++)
         chk(tb_bytes[1][k+1] == b[8*k +: 8], "R7 burst data byte",
             {56'd0, tb_bytes[1][k+1]}, {56'd0, b[8*k +: 8]});
      chk(tb_bytes[1][8] == 8'h80, "R7 protect set last", {56'd0, tb_bytes[1][8]}, 64'h80);
      chk(gap_min >= HOLH * HALF * TCK, "R5 gap between transactions",
          64'(gap_min), 64'(HOLH * HALF * TCK));
   endtask

   task automatic t_bad_op();
      clr_model();
      issue(2'b11, '0);
      repeat (20) @(negedge clk);
      chk(!busy && ntxn == 0 && !rtc_ce, "R2 reserved op ignored", 64'(ntxn), 64'd0);
   endtask

   initial begin
      clr_model();
      set_dev('0);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_read_ok();
      t_read_bad_bits();
      t_read_zero_month();
      t_protect();
      t_set();
      t_bad_op();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule